// File: doc/BRIEF.md
# Bounded Operand Stack Register File

This block is the register file of a stack-oriented 32-bit core. Instead of naming registers by absolute index, every operand is addressed by its distance below the live top of stack. A depth counter records how many entries are occupied, and each operation is checked against that depth and against the fixed capacity before it may touch storage.

The core presents one operation per cycle together with an offset and write data. Reads are combinational from the offset. Pushes, pops, in-place writes and a combined pop-two/push-one operation take effect on the rising clock edge. An illegal request leaves the stored entries and the depth untouched. Instead it raises a registered overflow or underflow flag for the following cycle, so the surrounding core can fail the instruction cleanly.

Top module: `opstack_regfile`

## Requirements
- R1: Each entry holds 32-bit data. A legal push (op code 2) stores `push_data` at the new top and increments the depth by one at the clock edge.
- R2: The depth output `depth_o` always lies between 0 and `DEPTH` inclusive, and reset brings it to 0.
- R3: While the offset is below the depth, `rd_data_o` combinationally shows the entry that many places below the top, with offset 0 being the top. Otherwise it shows zero. A read request (op code 1) with such an offset changes no state.
- R4: A push when the depth equals `DEPTH` sets `ovf_o` for the next cycle and leaves the depth and all entries unchanged.
- R5: A pop (op code 3) with depth 0 sets `unf_o` for the next cycle and leaves the depth unchanged. A legal pop lowers the depth by one.
- R6: A read (op code 1) or an in-place write (op code 4) whose offset is not below the depth sets `unf_o` and changes nothing. A legal in-place write replaces the entry at that offset and keeps the depth.
- R7: A merge (op code 5) with depth of at least two removes the two top entries, places `push_data` on top, and leaves the depth one lower.
- R8: A merge with depth below two sets `unf_o` and changes neither depth nor entries.
- R9: The fault flags describe only the operation accepted at the previous edge. Any non-faulting operation, including no-op (op code 0, and the unused codes 6 and 7), clears both flags.
- R10: Synchronous active-high reset clears the depth and both fault flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code: 0 none, 1 read, 2 push, 3 pop, 4 write at offset, 5 merge |
| ofs_i | input | 4 | Offset below the top of stack (`$clog2(DEPTH)` bits) |
| push_data | input | 32 | Data for push, in-place write and merge |
| rd_data_o | output | 32 | Entry at `ofs_i` below the top, zero when out of range |
| depth_o | output | 5 | Number of occupied entries (`$clog2(DEPTH+1)` bits) |
| ovf_o | output | 1 | Previous operation was a push onto a full stack |
| unf_o | output | 1 | Previous operation reached below the bottom of the stack |

## Verification
The bench fills the stack to capacity and then pushes once more. A design whose capacity check is off by one would either corrupt a slot past the end or refuse the last legal push. Reads and writes at offsets equal to the depth, and pops and merges on an empty or single-entry stack, expose guards that count from the wrong end or let a faulting request still move the depth. The bench checks that flags clear on the next clean operation, which catches sticky flags. Long random runs compare every offset's read data against a queue model, which catches reversed top-relative indexing.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_WRITE = 3'd4,
        OP_MERGE = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_INC  = 2'd1,
        ADJ_DEC  = 2'd2
    } depth_adj_e;

    // Decision for one cycle, produced by the guard.
    typedef struct packed {
        logic       wr_en;
        logic       ovf;
        logic       unf;
        depth_adj_e adj;
    } stk_ctl_t;

    function automatic stk_op_e decode_op(input logic [2:0] code);
        case (code)
            3'd1:    return OP_READ;
            3'd2:    return OP_PUSH;
            3'd3:    return OP_POP;
            3'd4:    return OP_WRITE;
            3'd5:    return OP_MERGE;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/opstack_guard.sv
module opstack_guard
    import opstack_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  stk_op_e           op,
    input  logic [IDX_W-1:0]  ofs,
    input  logic [CNT_W-1:0]  depth,
    output stk_ctl_t          ctl,
    output logic [IDX_W-1:0]  wr_idx
);
    logic [CNT_W-1:0] ofs_ext;
    logic             ofs_ok;
    logic [CNT_W-1:0] below_top;

    assign ofs_ext   = CNT_W'(ofs);
    assign ofs_ok    = ofs_ext < depth;
    assign below_top = depth - CNT_W'(1) - ofs_ext;

    always_comb begin
        ctl    = '{wr_en: 1'b0, ovf: 1'b0, unf: 1'b0, adj: ADJ_HOLD};
        wr_idx = '0;
        case (op)
            OP_READ: begin
                ctl.unf = !ofs_ok;
            end
            OP_PUSH: begin
                if (depth == CNT_W'(DEPTH)) begin
                    ctl.ovf = 1'b1;
                end else begin
                    ctl.wr_en = 1'b1;
                    ctl.adj   = ADJ_INC;
                    wr_idx    = IDX_W'(depth);
                end
            end
            OP_POP: begin
                if (depth == '0) ctl.unf = 1'b1;
                else             ctl.adj = ADJ_DEC;
            end
            OP_WRITE: begin
                if (!ofs_ok) begin
                    ctl.unf = 1'b1;
                end else begin
                    ctl.wr_en = 1'b1;
                    wr_idx    = IDX_W'(below_top);
                end
            end
            OP_MERGE: begin
                if (depth < CNT_W'(2)) begin
                    ctl.unf = 1'b1;
                end else begin
                    ctl.wr_en = 1'b1;
                    ctl.adj   = ADJ_DEC;
                    wr_idx    = IDX_W'(depth - CNT_W'(2));
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opstack_storage.sv
module opstack_storage #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) slot[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slot[i];
        end
    end
endmodule

// File: rtl/opstack_regfile.sv
module opstack_regfile
    import opstack_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [IDX_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  depth_o,
    output logic              ovf_o,
    output logic              unf_o
);
    stk_op_e           op;
    stk_ctl_t          ctl;
    logic [IDX_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  depth_q;
    logic [CNT_W-1:0]  ofs_ext;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] slot_data;

    assign op      = decode_op(op_i);
    assign ofs_ext = CNT_W'(ofs_i);
    assign rd_idx  = IDX_W'(depth_q - CNT_W'(1) - ofs_ext);

    opstack_guard #(.DEPTH(DEPTH)) u_guard (
        .op     (op),
        .ofs    (ofs_i),
        .depth  (depth_q),
        .ctl    (ctl),
        .wr_idx (wr_idx)
    );

    opstack_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (ctl.wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_idx  (rd_idx),
        .rd_data (slot_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            ovf_o   <= 1'b0;
            unf_o   <= 1'b0;
        end else begin
            ovf_o <= ctl.ovf;
            unf_o <= ctl.unf;
            case (ctl.adj)
                ADJ_INC: depth_q <= depth_q + CNT_W'(1);
                ADJ_DEC: depth_q <= depth_q - CNT_W'(1);
                default: ;
            endcase
        end
    end

    assign depth_o   = depth_q;
    assign rd_data_o = (ofs_ext < depth_q) ? slot_data : '0;

    assert_depth_bound_R2: assert property (@(posedge clk) disable iff (rst)
        depth_o <= CNT_W'(DEPTH));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2 && depth_o == CNT_W'(DEPTH)) |=> (ovf_o && $stable(depth_o)));

    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3 && depth_o == '0) |=> (unf_o && $stable(depth_o)));

    assert_push_grows_R1: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2 && depth_o < CNT_W'(DEPTH)) |=>
            (depth_o == $past(depth_o) + CNT_W'(1) && !ovf_o));

    assert_merge_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5 && depth_o >= CNT_W'(2)) |=>
            (depth_o == $past(depth_o) - CNT_W'(1) && !unf_o));

    assert_merge_short_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5 && depth_o < CNT_W'(2)) |=> (unf_o && $stable(depth_o)));

    assert_flags_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0) |=> (!ovf_o && !unf_o && $stable(depth_o)));
endmodule

// File: tb/sim_opstack_regfile.sv
module sim_opstack_regfile;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst;
    logic [2:0]        op_i;
    logic [IDX_W-1:0]  ofs_i;
    logic [DATA_W-1:0] push_data;
    logic [DATA_W-1:0] rd_data_o;
    logic [CNT_W-1:0]  depth_o;
    logic              ovf_o;
    logic              unf_o;

    int errors = 0;
    int checks = 0;
    logic [DATA_W-1:0] mdl [$];   // mdl[$] is the top
    bit m_ovf = 0;
    bit m_unf = 0;

    always #5 clk = ~clk;

    opstack_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .ofs_i(ofs_i),
        .push_data(push_data), .rd_data_o(rd_data_o),
        .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] peek(input int k);
        if (k < mdl.size()) return mdl[mdl.size() - 1 - k];
        return '0;
    endfunction

    // One cycle: compare registered state, drive, compare read port, clock, update model.
    task automatic step(input logic [2:0] op, input int ofs, input logic [DATA_W-1:0] d);
        int n;
        @(negedge clk);
        check("R2 depth", depth_o, mdl.size());
        check("R4 ovf flag", ovf_o, m_ovf);
        check("R5 R6 R8 unf flag", unf_o, m_unf);
        op_i = op; ofs_i = IDX_W'(ofs); push_data = d;
        #1;
        check("R3 read data", rd_data_o, peek(ofs));
        @(posedge clk);
        n = mdl.size();
        m_ovf = 0; m_unf = 0;
        case (op)
            3'd1: m_unf = (ofs >= n);
            3'd2: if (n == DEPTH) m_ovf = 1; else mdl.push_back(d);
            3'd3: if (n == 0) m_unf = 1; else void'(mdl.pop_back());
            3'd4: if (ofs >= n) m_unf = 1; else mdl[n - 1 - ofs] = d;
            3'd5: if (n < 2) m_unf = 1;
                  else begin void'(mdl.pop_back()); mdl[n - 2] = d; end
            default: ;
        endcase
    endtask

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = 3'd0; ofs_i = '0; push_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10 depth after reset", depth_o, 0);
        check("R10 flags after reset", {ovf_o, unf_o}, 0);

        // R5 pop and R8 merge on empty, R6 read/write beyond depth
        step(3'd3, 0, 0);
        step(3'd5, 0, 32'h1111);
        step(3'd1, 0, 0);
        step(3'd4, 0, 32'hdead);
        // R1 fill to capacity
        for (int i = 0; i < DEPTH; i++) step(3'd2, 0, 32'hA500_0000 + i);
        // R4 push when full, twice, then a clean op (R9)
        step(3'd2, 0, 32'hBAD0_0001);
        step(3'd2, 3, 32'hBAD0_0002);
        step(3'd0, 0, 0);
        // R3 read every offset
        for (int k = 0; k < DEPTH; k++) step(3'd1, k, 0);
        // R6 in-place writes
        step(3'd4, 0, 32'h0000_0010);
        step(3'd4, DEPTH - 1, 32'h0000_0020);
        // R7 merge down to one entry, then R8 merge with one
        for (int i = 0; i < DEPTH - 1; i++) step(3'd5, i % DEPTH, 32'hC000_0000 + i);
        step(3'd5, 0, 32'hFFFF_FFFF);
        step(3'd1, 1, 0);
        step(3'd1, 0, 0);
        step(3'd3, 0, 0);
        step(3'd3, 0, 0);
        step(3'd7, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] rop;
            rop = 3'($urandom_range(0, 7));
            if (mdl.size() < 4 && rop == 3'd3) rop = 3'd2;
            step(rop, int'($urandom_range(0, DEPTH - 1)), $urandom);
        end
        step(3'd0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule